// File: doc/BRIEF.md
# Autobaud Single-Wire Register Slave

This block is a half-duplex serial slave on one shared open-drain line. A host opens every transaction with a fixed sync character. The slave times that character with the system clock to learn the bit period, and uses that period for every later bit of the same transaction. Each transaction learns its rate afresh, so the host may change speed from one transaction to the next.

After the sync character the host sends a command byte that names one of sixteen 16-bit registers and chooses between read and write. For a write, the host then sends two data bytes and the slave strobes a simple register-file port. For a read, the slave waits a short turnaround and then sends the register contents back as two bytes on the same wire. It can only pull the wire low; an external pull-up makes the high level. An idle timer drops a transaction that stalls between bytes. A one-cycle activity pulse marks each byte accepted, for use by neighbouring logic.

Top module: `swire_regif`

## Requirements
- R1: Each transaction starts with the character 0x55. The bit period used for the rest of that transaction is one eighth of the clock count between the first and the fifth falling edge of that character. Successive transactions may use different periods.
- R2: Bit periods from 16 clocks up to the period whose eight-fold count still fits in MEAS_W bits are received and sent correctly. The default covers 4.8 kbit/s at 100 MHz.
- R3: A character is one start bit (0), eight data bits sent least significant bit first, and one stop bit (1), sampled at mid-bit. If the stop bit of any character, the sync character included, samples as 0, the transaction is dropped with no register write, and the slave waits for a new sync character.
- R4: In the command byte, bit 7 (the last data bit sent) selects read (1) or write (0). Bits 3:0 are the register address, and bits 6:4 are ignored.
- R5: A write carries two data bytes, low byte first. After the high byte's stop bit, exactly one single-cycle reg_we pulse is issued, with reg_addr set to the address and reg_wdata set to {high, low}.
- R6: On a read, the start bit of the first reply byte begins READ_GAP_BITS bit periods (default 2) after the end of the command byte's stop bit.
- R7: The read reply is two characters at the measured rate, low byte of reg_rdata first, then high byte, each with a stop bit of 1. reg_addr stays constant during the reply.
- R8: line_pull (1 = pull the wire low) is asserted only while a reply is being sent, and only for its 0 bits. At all other times the wire is released.
- R9: If TIMEOUT_CYC clocks pass inside a transaction without a completed character, the slave abandons it and waits for a sync character.
- R10: The idle timer restarts at every accepted character, so a transaction whose total length exceeds TIMEOUT_CYC still completes when each gap is shorter.
- R11: activity pulses for one cycle per accepted character: four per write transaction, two per read (sync and command).
- R12: After reset, line_pull, reg_we and activity are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level of the shared wire (asynchronous) |
| line_pull | output | 1 | 1 pulls the shared wire low |
| activity | output | 1 | One-cycle pulse per accepted character |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 16 | Register write data |
| reg_we | output | 1 | Register write strobe |
| reg_rdata | input | 16 | Register read data for reg_addr |

## Verification
The bench changes the bit period between transactions, from 16 clocks to 500 clocks. A slave that kept an old rate, or that shifted the measured count by the wrong amount, would misread the command and write the wrong register. It corrupts the stop bit once in the sync character and once in a write's high byte. A slave that ignored framing would then perform a stray write, or would take the next sync character as a command. It stalls a transaction past the timeout, and then spaces the bytes of another transaction so that their total exceeds the timeout while each gap stays under it. This catches a timer that never fires as well as one that is not restarted. It also sets the ignored command bits and measures the read turnaround, which exposes a wrong address mask or a reply that starts early and collides with the host.

// File: rtl/swire_pkg.sv
package swire_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_MEAS  = 3'd1,
        S_MSTOP = 3'd2,
        S_WAIT  = 3'd3,
        S_RX    = 3'd4,
        S_GAP   = 3'd5,
        S_TXLO  = 3'd6,
        S_TXHI  = 3'd7
    } state_e;

    localparam int BYTE_W    = 8;
    localparam int STOP_IDX  = 9;
    localparam int SYNC_FALL = 4;  // falls after the first one
endpackage

// File: rtl/swire_line_sync.sv
module swire_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall
);
    logic [2:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[1:0], line_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= 3'b111;
        else        sr_q <= sr_d;
    end

    assign line_s = sr_q[1];
    assign fall   = sr_q[2] & ~sr_q[1];
endmodule

// File: rtl/swire_idle_timer.sv
module swire_idle_timer #(
    parameter int LIMIT = 2_800_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !en)                cnt_d = '0;
        else if (cnt_q != TW'(LIMIT))  cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = en && (cnt_q == TW'(LIMIT));
endmodule

// File: rtl/swire_tx.sv
module swire_tx #(
    parameter int BIT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       byte_in,
    input  logic [BIT_W-1:0] bitp,
    output logic             pull,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [BIT_W-1:0] cnt;
        logic [3:0]       idx;
        logic [9:0]       sh;
    } tx_t;

    tx_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.busy = 1'b1;
            r_d.sh   = {1'b1, byte_in, 1'b0};
            r_d.cnt  = bitp - BIT_W'(1);
            r_d.idx  = '0;
        end else if (r_q.busy) begin
            if (r_q.cnt == '0) begin
                if (r_q.idx == 4'(swire_pkg::STOP_IDX)) begin
                    r_d.busy = 1'b0;
                end else begin
                    r_d.idx = r_q.idx + 4'd1;
                    r_d.sh  = {1'b1, r_q.sh[9:1]};
                    r_d.cnt = bitp - BIT_W'(1);
                end
            end else begin
                r_d.cnt = r_q.cnt - BIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pull = r_q.busy & ~r_q.sh[0];
    assign done = r_q.busy && (r_q.cnt == '0) && (r_q.idx == 4'(swire_pkg::STOP_IDX));
endmodule

// File: rtl/swire_regif.sv
module swire_regif
    import swire_pkg::*;
#(
    parameter int MEAS_W        = 18,
    parameter int TIMEOUT_CYC   = 2_800_000,
    parameter int READ_GAP_BITS = 2,
    parameter int ADDR_W        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    output logic              line_pull,
    output logic              activity,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [15:0]       reg_wdata,
    output logic              reg_we,
    input  logic [15:0]       reg_rdata
);
    localparam int BIT_W = MEAS_W - 3;

    typedef struct packed {
        state_e            st;
        logic [MEAS_W-1:0] meas;
        logic [2:0]        falls;
        logic [BIT_W-1:0]  bitp;
        logic [MEAS_W-1:0] cnt;
        logic [3:0]        idx;
        logic [7:0]        sh;
        logic [1:0]        phase;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        lo;
        logic [15:0]       rdat;
        logic [15:0]       wd;
        logic [7:0]        txb;
        logic              we;
        logic              act;
        logic              go;
    } ctl_t;

    ctl_t r_d, r_q;
    state_e st_w;

    logic line_s, fall, tx_done, tmo_exp, tmr_en;
    logic [BIT_W-1:0]  meas_bp;
    logic [MEAS_W-1:0] half_w, gap_w, stop_w;

    swire_line_sync sync_i (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_s(line_s), .fall(fall)
    );

    assign tmr_en = (r_q.st == S_MEAS) || (r_q.st == S_MSTOP) ||
                    (r_q.st == S_WAIT) || (r_q.st == S_RX);

    swire_idle_timer #(.LIMIT(TIMEOUT_CYC)) tmr_i (
        .clk(clk), .rst_n(rst_n), .en(tmr_en), .clr(r_q.act), .expired(tmo_exp)
    );

    swire_tx #(.BIT_W(BIT_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .start(r_q.go), .byte_in(r_q.txb),
        .bitp(r_q.bitp), .pull(line_pull), .done(tx_done)
    );

    assign meas_bp = r_q.meas[MEAS_W-1:3];
    assign stop_w  = MEAS_W'(meas_bp) + MEAS_W'(meas_bp >> 1) - MEAS_W'(1);
    assign half_w  = MEAS_W'(r_q.bitp >> 1);
    assign gap_w   = half_w + MEAS_W'(READ_GAP_BITS) * MEAS_W'(r_q.bitp) - MEAS_W'(1);

    always_comb begin
        r_d     = r_q;
        r_d.we  = 1'b0;
        r_d.act = 1'b0;
        r_d.go  = 1'b0;
        case (r_q.st)
            S_IDLE: if (fall) begin
                r_d.st    = S_MEAS;
                r_d.meas  = MEAS_W'(1);
                r_d.falls = '0;
            end
            S_MEAS: begin
                r_d.meas = r_q.meas + MEAS_W'(1);
                if (fall) begin
                    r_d.falls = r_q.falls + 3'd1;
                    if (r_q.falls == 3'(SYNC_FALL - 1)) begin
                        r_d.bitp = meas_bp;
                        r_d.cnt  = stop_w;
                        r_d.st   = S_MSTOP;
                    end
                end
            end
            S_MSTOP: begin
                if (r_q.cnt == '0) begin
                    if (line_s) begin
                        r_d.st    = S_WAIT;
                        r_d.phase = '0;
                        r_d.act   = 1'b1;
                    end else begin
                        r_d.st = S_IDLE;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - MEAS_W'(1);
                end
            end
            S_WAIT: if (fall) begin
                r_d.st  = S_RX;
                r_d.cnt = half_w - MEAS_W'(1);
                r_d.idx = '0;
            end
            S_RX: begin
                if (r_q.cnt == '0) begin
                    r_d.cnt = MEAS_W'(r_q.bitp) - MEAS_W'(1);
                    r_d.idx = r_q.idx + 4'd1;
                    if (r_q.idx != 4'd0 && r_q.idx != 4'(STOP_IDX))
                        r_d.sh = {line_s, r_q.sh[7:1]};
                    if (r_q.idx == 4'(STOP_IDX)) begin
                        if (!line_s) begin
                            r_d.st = S_IDLE;
                        end else begin
                            r_d.act = 1'b1;
                            case (r_q.phase)
                                2'd0: begin
                                    r_d.addr = r_q.sh[ADDR_W-1:0];
                                    if (r_q.sh[7]) begin
                                        r_d.st  = S_GAP;
                                        r_d.cnt = gap_w;
                                    end else begin
                                        r_d.st    = S_WAIT;
                                        r_d.phase = 2'd1;
                                    end
                                end
                                2'd1: begin
                                    r_d.lo    = r_q.sh;
                                    r_d.phase = 2'd2;
                                    r_d.st    = S_WAIT;
                                end
                                default: begin
                                    r_d.wd = {r_q.sh, r_q.lo};
                                    r_d.we = 1'b1;
                                    r_d.st = S_IDLE;
                                end
                            endcase
                        end
                    end
                end else begin
                    r_d.cnt = r_q.cnt - MEAS_W'(1);
                end
            end
            S_GAP: begin
                if (r_q.cnt == '0) begin
                    r_d.rdat = reg_rdata;
                    r_d.txb  = reg_rdata[7:0];
                    r_d.go   = 1'b1;
                    r_d.st   = S_TXLO;
                end else begin
                    r_d.cnt = r_q.cnt - MEAS_W'(1);
                end
            end
            S_TXLO: if (tx_done) begin
                r_d.txb = r_q.rdat[15:8];
                r_d.go  = 1'b1;
                r_d.st  = S_TXHI;
            end
            S_TXHI: if (tx_done) r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
        if (tmo_exp) r_d.st = S_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign st_w      = r_q.st;
    assign activity  = r_q.act;
    assign reg_we    = r_q.we;
    assign reg_wdata = r_q.wd;
    assign reg_addr  = r_q.addr;
endmodule

// File: rtl/swire_regif_chk.sv
module swire_regif_chk
    import swire_pkg::*;
#(
    parameter int TIMEOUT_CYC = 2_800_000,
    parameter int ADDR_W      = 4
) (
    input logic              clk,
    input logic              rst_n,
    input state_e            st,
    input logic              line_pull,
    input logic              reg_we,
    input logic              activity,
    input logic [ADDR_W-1:0] reg_addr
);
    logic in_txn, in_reply;
    int unsigned quiet_q;

    assign in_txn   = (st == S_MEAS) || (st == S_MSTOP) || (st == S_WAIT) || (st == S_RX);
    assign in_reply = (st == S_TXLO) || (st == S_TXHI);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   quiet_q <= 0;
        else if (activity || !in_txn) quiet_q <= 0;
        else                          quiet_q <= quiet_q + 1;
    end

    // R8: the wire is pulled only while a reply is being sent
    a_r8_pull_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
        line_pull |-> in_reply);

    // R5: the write strobe lasts a single cycle
    a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5: no strobe while the slave drives the wire
    a_r5_we_not_in_reply: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !line_pull);

    // R11: activity is a one-cycle pulse
    a_r11_act_single: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !activity);

    // R7: the address is held through the reply
    a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_TXHI) |-> $stable(reg_addr));

    // R9: no transaction sits idle longer than the timeout
    a_r9_timeout_bound: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_q <= TIMEOUT_CYC + 2);
endmodule

bind swire_regif swire_regif_chk #(.TIMEOUT_CYC(TIMEOUT_CYC), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .st(st_w), .line_pull(line_pull),
    .reg_we(reg_we), .activity(activity), .reg_addr(reg_addr)
);

// File: tb/swire_regif_tb.sv
module swire_regif_tb_top;
    localparam int TMO = 6000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_drv = 1'b1;
    logic line_pull, activity, reg_we;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    wire line = host_drv & ~line_pull;

    logic [15:0] regs [0:15];
    logic [19:0] exp_q [$];
    int total = 0, bad = 0, act_cnt = 0, wr_seen = 0;
    bit resp_win = 1'b0;

    always #5 clk = ~clk;

    swire_regif #(.MEAS_W(18), .TIMEOUT_CYC(TMO), .READ_GAP_BITS(2), .ADDR_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .line_in(line), .line_pull(line_pull),
        .activity(activity), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign reg_rdata = regs[reg_addr];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock reference: register model, strobe expectations, wire ownership
    always @(negedge clk) begin
        if (rst_n) begin
            if (activity) act_cnt++;
            if (line_pull && !resp_win)
                chk(1'b0, "R8", "pull outside reply", 1, 0);
            if (reg_we) begin
                logic [19:0] e;
                wr_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5", "unexpected write", {reg_addr, reg_wdata}, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk({reg_addr, reg_wdata} == e, "R5", "write addr/data",
                        {reg_addr, reg_wdata}, e);
                end
                regs[reg_addr] = reg_wdata;
            end
        end
    end

    task automatic send_byte(input logic [7:0] b, input int p, input bit stp);
        host_drv = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            host_drv = b[i];
            repeat (p) @(negedge clk);
        end
        host_drv = stp;
        repeat (p) @(negedge clk);
        host_drv = 1'b1;
    endtask

    task automatic recv_byte(input int p, output logic [7:0] b, output logic stp);
        while (line) @(negedge clk);
        repeat (p / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (p) @(negedge clk);
            b[i] = line;
        end
        repeat (p) @(negedge clk);
        stp = line;
    endtask

    task automatic do_write(input logic [3:0] a, input logic [15:0] d, input int p,
                            input logic [2:0] hi3, input bit stop_hi, input int gap);
        if (stop_hi) exp_q.push_back({a, d});
        send_byte(8'h55, p, 1'b1);
        repeat (gap) @(negedge clk);
        send_byte({1'b0, hi3, a}, p, 1'b1);
        repeat (gap) @(negedge clk);
        send_byte(d[7:0], p, 1'b1);
        repeat (gap) @(negedge clk);
        send_byte(d[15:8], p, stop_hi);
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] cmd, input int p,
                           output logic [15:0] v, output int gap, output logic [1:0] stops);
        logic [7:0] lo, hi;
        logic s0, s1;
        send_byte(8'h55, p, 1'b1);
        send_byte(cmd, p, 1'b1);
        resp_win = 1'b1;
        gap = 0;
        while (!line_pull) begin
            @(negedge clk);
            gap++;
        end
        recv_byte(p, lo, s0);
        recv_byte(p, hi, s1);
        repeat (p) @(negedge clk);
        resp_win = 1'b0;
        v = {hi, lo};
        stops = {s1, s0};
    endtask

    task automatic read_chk(input logic [7:0] cmd, input int p, input logic [15:0] exp,
                            input string req);
        logic [15:0] v;
        int g;
        logic [1:0] s;
        do_read(cmd, p, v, g, s);
        chk(v == exp, req, "read value", v, exp);
        chk(s == 2'b11, "R7", "reply stop bits", s, 3);
        chk(g >= 2 * p - 2 && g <= 2 * p + p / 8 + 8, "R6", "turnaround cycles", g, 2 * p);
    endtask

    initial begin
        int a0, w0;
        for (int i = 0; i < 16; i++) regs[i] = 16'h1000 + 16'(i);
        repeat (3) @(negedge clk);
        chk(line_pull == 1'b0, "R12", "pull in reset", line_pull, 0);
        chk(reg_we == 1'b0, "R12", "we in reset", reg_we, 0);
        chk(activity == 1'b0, "R12", "activity in reset", activity, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(line_pull == 1'b0 && reg_we == 1'b0, "R12", "outputs after reset", line_pull, 0);

        // R1 R5 R11: write at 40 clocks per bit
        a0 = act_cnt;
        do_write(4'd2, 16'hBEEF, 40, 3'd0, 1'b1, 0);
        chk(act_cnt - a0 == 4, "R11", "pulses per write", act_cnt - a0, 4);
        chk(regs[2] == 16'hBEEF, "R5", "write landed", regs[2], 16'hBEEF);

        // R1 R6 R7 R11: read at a different rate
        a0 = act_cnt;
        read_chk(8'h82, 64, 16'hBEEF, "R1");
        chk(act_cnt - a0 == 2, "R11", "pulses per read", act_cnt - a0, 2);

        // R2 R4: fastest rate, ignored command bits set
        do_write(4'd5, 16'h1234, 16, 3'b111, 1'b1, 0);
        chk(regs[5] == 16'h1234, "R4", "address masked", regs[5], 16'h1234);
        read_chk(8'h85, 500, 16'h1234, "R2");
        read_chk(8'hF2, 16, 16'hBEEF, "R4");
        read_chk(8'h8C, 40, 16'h100C, "R7");

        // R3: bad stop on the high data byte drops the write
        w0 = wr_seen;
        do_write(4'd2, 16'h5555, 40, 3'd0, 1'b0, 0);
        repeat (40) @(negedge clk);
        chk(wr_seen == w0, "R3", "writes after bad data stop", wr_seen - w0, 0);
        read_chk(8'h82, 40, 16'hBEEF, "R3");

        // R3: bad stop on sync, then a clean write must still land
        send_byte(8'h55, 40, 1'b0);
        repeat (60) @(negedge clk);
        do_write(4'd7, 16'hA5C3, 40, 3'd0, 1'b1, 0);
        chk(regs[7] == 16'hA5C3, "R3", "write after bad sync", regs[7], 16'hA5C3);

        // R9: stall after the low byte
        w0 = wr_seen;
        send_byte(8'h55, 40, 1'b1);
        send_byte(8'h02, 40, 1'b1);
        send_byte(8'h11, 40, 1'b1);
        repeat (TMO + 1000) @(negedge clk);
        send_byte(8'hAB, 40, 1'b1);
        repeat (TMO + 1000) @(negedge clk);
        chk(wr_seen == w0, "R9", "writes after timeout", wr_seen - w0, 0);
        read_chk(8'h82, 40, 16'hBEEF, "R9");

        // R10: long transaction with short gaps
        do_write(4'd9, 16'h0F0F, 40, 3'd0, 1'b1, 4500);
        chk(regs[9] == 16'h0F0F, "R10", "write with spaced bytes", regs[9], 16'h0F0F);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "pending writes", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule